// File: doc/BRIEF.md
# Receive Frame Length Limiter

This block sits in a receive path between a MAC byte stream and the logic that moves frame data into memory. Each frame is counted from its first destination-address byte through its last CRC byte. Bytes beyond a programmable maximum length are dropped. The four CRC bytes that close every accepted stretch are held back, so the downstream side receives only header and payload bytes. At the end of every frame the block reports the total number of bytes received and whether that total exceeded the limit.

The limit comes from a 12-bit field in a 32-bit register. The programmed value is clamped into the window 1518 to 2048. The clamped value is captured when a frame starts, so a write made during a frame changes only the frames that start after it. Frames that are too long are never aborted: the surplus bytes are simply not forwarded.

Top module: `rx_len_limiter`

## Requirements
- R1: After reset, the register reads zero, and `out_valid`, `out_last` and `stat_valid` are low.
- R2: A write stores `reg_wdata[11:0]`. Bits 31..12 of `reg_wdata` are ignored. `reg_rdata` returns the stored field in bits 11..0 and zero in bits 31..12, from the cycle after the write.
- R3: A stored field between 0x000 and 0x5EE gives an effective limit of 1518 bytes.
- R4: A stored field between 0x5EF and 0x7FF gives an effective limit equal to the field value.
- R5: A stored field between 0x800 and 0xFFF gives an effective limit of 2048 bytes.
- R6: A frame of N bytes accepts its first min(N, L) bytes, where L is the effective limit and the count includes the CRC bytes. All later bytes of that frame are discarded.
- R7: The last four accepted bytes of every frame are never forwarded, so a frame forwards max(min(N, L) − 4, 0) bytes. `out_last` is high on the final forwarded byte only. A frame with four or fewer accepted bytes forwards nothing.
- R8: One cycle after the byte that carries the end-of-frame strobe, `stat_valid` pulses for one cycle. With it, `stat_len` gives N saturated at 4095, and `stat_over` is high exactly when N > L.
- R9: L is captured at the start-of-frame byte, from the register value held before that cycle's write. A write during a frame does not change that frame.
- R10: Forwarded bytes come out in arrival order with unchanged values, whatever idle cycles separate the input bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| out_valid | output | 1 | Forwarded byte valid |
| out_data | output | 8 | Forwarded byte |
| out_last | output | 1 | Final forwarded byte of a frame |
| stat_valid | output | 1 | Per-frame status strobe |
| stat_len | output | 12 | Bytes received in the frame, saturated |
| stat_over | output | 1 | Frame exceeded the effective limit |

## Verification
The properties take a well-formed input stream for granted. `in_sof` and `in_eof` are only high together with `in_valid`. `in_sof` marks the first byte of every frame and `in_eof` marks its last byte, so frames never overlap or go unterminated. The bench builds each frame as one contiguous sequence that opens with a start strobe and closes with an end strobe, and may insert idle cycles inside it. Register writes come either between frames or on one chosen byte in the middle of a frame, never on the start-of-frame byte itself.

// File: rtl/rxl_pkg.sv
package rxl_pkg;
  localparam int LEN_W = 12;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] v,
                                                 input logic [LEN_W-1:0] lo,
                                                 input logic [LEN_W-1:0] hi);
    if (v < lo) return lo;
    else if (v > hi) return hi;
    else return v;
  endfunction
endpackage

// File: rtl/rxl_limit_reg.sv
module rxl_limit_reg #(
  parameter int RW      = 32,
  parameter int LW      = 12,
  parameter int MIN_LEN = 1518,
  parameter int MAX_LEN = 2048
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [RW-1:0] wdata,
  output logic [RW-1:0] rdata,
  output logic [LW-1:0] eff
);
  logic [LW-1:0] field_q;
  wire unused_hi = ^wdata[RW-1:LW];

  always_ff @(posedge clk) begin
    if (rst) field_q <= '0;
    else if (wr) field_q <= wdata[LW-1:0];
  end

  assign rdata = {{(RW-LW){1'b0}}, field_q};
  assign eff   = rxl_pkg::clamp_len(field_q, LW'(MIN_LEN), LW'(MAX_LEN));
endmodule

// File: rtl/rxl_frame_counter.sv
module rxl_frame_counter #(
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic [LW-1:0] eff,
  output logic          accept,
  output logic          stat_valid,
  output logic [LW-1:0] stat_len,
  output logic          stat_over
);
  logic [LW-1:0] cnt_q, lim_q, cur, lim_use, nxt_sat;
  logic [LW:0]   nxt_w;

  always_comb begin
    cur     = in_sof ? '0 : cnt_q;
    lim_use = in_sof ? eff : lim_q;
    nxt_w   = {1'b0, cur} + 1'b1;
    nxt_sat = nxt_w[LW] ? '1 : nxt_w[LW-1:0];
    accept  = in_valid && (cur < lim_use);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      lim_q      <= '0;
      stat_valid <= 1'b0;
      stat_len   <= '0;
      stat_over  <= 1'b0;
    end else begin
      stat_valid <= in_valid && in_eof;
      if (in_valid) begin
        cnt_q     <= nxt_sat;
        stat_len  <= nxt_sat;
        stat_over <= nxt_w > {1'b0, lim_use};
        if (in_sof) lim_q <= eff;
      end
    end
  end
endmodule

// File: rtl/rxl_trailer_strip.sv
module rxl_trailer_strip #(
  parameter int DW    = 8,
  parameter int TRAIL = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          eof,
  input  logic [DW-1:0] din,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_last
);
  localparam int HW = $clog2(TRAIL + 1);

  logic [DW-1:0] line_q [TRAIL];
  logic [HW-1:0] held_q;
  logic [DW-1:0] pend_q;
  logic          pend_v_q, flush_q;
  logic          full, shift_out;

  assign full      = (held_q == HW'(TRAIL));
  assign shift_out = push && full;

  always_ff @(posedge clk) begin
    if (push) begin
      for (int k = TRAIL - 1; k > 0; k--) line_q[k] <= line_q[k-1];
      line_q[0] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q    <= '0;
      pend_q    <= '0;
      pend_v_q  <= 1'b0;
      flush_q   <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      if (flush_q) begin
        out_valid <= 1'b1;
        out_data  <= pend_q;
        out_last  <= 1'b1;
        pend_v_q  <= 1'b0;
        flush_q   <= 1'b0;
      end
      if (push && !full) held_q <= held_q + 1'b1;
      if (shift_out) begin
        if (pend_v_q) begin
          out_valid <= 1'b1;
          out_data  <= pend_q;
        end
        pend_q   <= line_q[TRAIL-1];
        pend_v_q <= 1'b1;
      end
      if (eof) begin
        held_q <= '0;
        if (shift_out) flush_q <= 1'b1;
        else if (pend_v_q && !flush_q) begin
          out_valid <= 1'b1;
          out_data  <= pend_q;
          out_last  <= 1'b1;
          pend_v_q  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/rx_len_limiter.sv
module rx_len_limiter #(
  parameter int RW      = 32,
  parameter int LW      = rxl_pkg::LEN_W,
  parameter int DW      = 8,
  parameter int MIN_LEN = 1518,
  parameter int MAX_LEN = 2048,
  parameter int TRAIL   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_sof,
  input  logic          in_eof,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  output logic          stat_valid,
  output logic [LW-1:0] stat_len,
  output logic          stat_over
);
  logic [LW-1:0] eff_lim;
  logic          accept;

  rxl_limit_reg #(.RW(RW), .LW(LW), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_reg (
    .clk(clk), .rst(rst), .wr(reg_wr), .wdata(reg_wdata),
    .rdata(reg_rdata), .eff(eff_lim)
  );

  rxl_frame_counter #(.LW(LW)) u_cnt (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .eff(eff_lim), .accept(accept), .stat_valid(stat_valid),
    .stat_len(stat_len), .stat_over(stat_over)
  );

  rxl_trailer_strip #(.DW(DW), .TRAIL(TRAIL)) u_strip (
    .clk(clk), .rst(rst), .push(accept), .eof(in_valid && in_eof), .din(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );
endmodule

// File: rtl/rx_len_limiter_chk.sv
module rx_len_limiter_chk #(
  parameter int RW      = 32,
  parameter int LW      = 12,
  parameter int MIN_LEN = 1518,
  parameter int MAX_LEN = 2048,
  parameter int TRAIL   = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_wr,
  input logic [LW-1:0] wr_lo,
  input logic [RW-1:0] reg_rdata,
  input logic          in_valid,
  input logic          in_eof,
  input logic          out_valid,
  input logic          out_last,
  input logic          stat_valid,
  input logic [LW-1:0] stat_len,
  input logic          stat_over
);
  logic [15:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) run_cnt <= '0;
    else if (out_valid) run_cnt <= out_last ? '0 : run_cnt + 1'b1;
  end

  // R7
  last_on_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  // R8
  stat_after_eof_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_eof) |=> stat_valid);

  // R8
  stat_needs_eof_chk: assert property (@(posedge clk) disable iff (rst)
    stat_valid |-> $past(in_valid && in_eof));

  // R2
  reg_write_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> (reg_rdata[LW-1:0] == $past(wr_lo)) && (reg_rdata[RW-1:LW] == '0));

  // R3
  over_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && stat_over) |-> (stat_len > LW'(MIN_LEN)));

  // R6
  fwd_bound_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (run_cnt < 16'(MAX_LEN - TRAIL)));
endmodule

bind rx_len_limiter rx_len_limiter_chk #(
  .RW(RW), .LW(LW), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .TRAIL(TRAIL)
) chk_i (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .wr_lo(reg_wdata[LW-1:0]),
  .reg_rdata(reg_rdata), .in_valid(in_valid), .in_eof(in_eof),
  .out_valid(out_valid), .out_last(out_last), .stat_valid(stat_valid),
  .stat_len(stat_len), .stat_over(stat_over)
);

// File: tb/rx_len_limiter_test.sv
module rx_len_limiter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_sof = 1'b0;
  logic        in_eof = 1'b0;
  logic        out_valid, out_last, stat_valid, stat_over;
  logic [7:0]  out_data;
  logic [11:0] stat_len;

  always #4 clk = ~clk;

  rx_len_limiter uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .stat_valid(stat_valid), .stat_len(stat_len), .stat_over(stat_over)
  );

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  logic [11:0] shadow = '0;
  logic [8:0] exp_q[$];
  int    st_len_q[$];
  bit    st_over_q[$];
  int    st_due_q[$];
  string st_tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int lim_of(logic [11:0] v);
    if (v < 12'd1518) return 1518;
    if (v > 12'd2047) return 2048;
    return int'(v);
  endfunction

  function automatic logic [7:0] byte_of(int seed, int i);
    return 8'((seed * 31 + i * 7 + (i >> 8)) & 255);
  endfunction

  // per-clock comparison against the behavioural model
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      if (out_valid) begin
        if (exp_q.size() == 0) check(0, "R6", "unexpected forwarded byte", 1, 0);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          check({out_last, out_data} == e, "R7/R10", "forwarded {last,data}",
                int'({out_last, out_data}), int'(e));
        end
      end
      if (stat_valid) begin
        if (st_len_q.size() == 0) check(0, "R8", "unexpected status strobe", 1, 0);
        else begin
          int    l, d;
          bit    o;
          string t;
          l = st_len_q.pop_front(); o = st_over_q.pop_front();
          d = st_due_q.pop_front(); t = st_tag_q.pop_front();
          check(d == cyc, {"R8 ", t}, "status cycle", cyc, d);
          check(int'(stat_len) == l, {"R8 ", t}, "status length", int'(stat_len), l);
          check(stat_over == o, {"R6 ", t}, "overlength flag", int'(stat_over), int'(o));
        end
      end else if (st_due_q.size() != 0 && st_due_q[0] <= cyc) begin
        check(0, {"R8 ", st_tag_q[0]}, "missing status strobe", 0, 1);
        void'(st_len_q.pop_front()); void'(st_over_q.pop_front());
        void'(st_due_q.pop_front()); void'(st_tag_q.pop_front());
      end
    end
  end

  task automatic idle();
    in_valid = 0; in_sof = 0; in_eof = 0; reg_wr = 0;
  endtask

  task automatic write_reg(logic [31:0] v);
    @(negedge clk); idle(); reg_wr = 1; reg_wdata = v;
    @(negedge clk); reg_wr = 0;
    shadow = v[11:0];
    check(reg_rdata == {20'd0, v[11:0]}, "R2", "register readback",
          int'(reg_rdata), int'({20'd0, v[11:0]}));
  endtask

  task automatic send(int n, int seed, int gap, int wr_at, logic [31:0] wr_val, string tag);
    int L, a;
    L = lim_of(shadow);
    a = (n < L) ? n : L;
    for (int i = 0; i < a - 4; i++) exp_q.push_back({(i == a - 5), byte_of(seed, i)});
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = byte_of(seed, i);
      in_sof = (i == 0); in_eof = (i == n - 1);
      reg_wr = (i == wr_at); reg_wdata = wr_val;
      if (i == wr_at) shadow = wr_val[11:0];
      if (i == n - 1) begin
        st_len_q.push_back(n > 4095 ? 4095 : n);
        st_over_q.push_back(n > L);
        st_due_q.push_back(cyc + 1);
        st_tag_q.push_back(tag);
      end
      if (gap > 0 && (i % gap) == gap - 1 && i != n - 1) begin
        @(negedge clk); idle();
      end
    end
    @(negedge clk); idle();
  endtask

  task automatic drain(string req);
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, req, "bytes still expected", exp_q.size(), 0);
    check(st_len_q.size() == 0, req, "status still expected", st_len_q.size(), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(reg_rdata == 0, "R1", "register after reset", int'(reg_rdata), 0);
    check(out_valid == 0 && out_last == 0, "R1", "output idle", int'(out_valid), 0);
    check(stat_valid == 0, "R1", "status idle", int'(stat_valid), 0);

    // R2 upper bits ignored; R3 low clamp
    write_reg(32'hFFFF_F123);
    send(1530, 1, 0, -1, 0, "R3 field 0x123");
    write_reg(32'h0);
    send(1518, 2, 0, -1, 0, "R3 exact limit");
    drain("R3");

    // R7 short frames, R10 gaps
    send(64, 3, 3, -1, 0, "R10 gapped");
    send(1, 4, 0, -1, 0, "R7 one byte");
    send(4, 5, 0, -1, 0, "R7 four bytes");
    send(5, 6, 0, -1, 0, "R7 five bytes");
    send(6, 7, 2, -1, 0, "R7 six bytes");
    send(300, 8, 5, -1, 0, "R10 gapped long");
    drain("R7");

    // R3 / R4 boundaries
    write_reg(32'h0000_05EE);
    send(1519, 9, 0, -1, 0, "R3 field 0x5EE");
    write_reg(32'h0000_05EF);
    send(1520, 10, 0, -1, 0, "R4 field 0x5EF");
    write_reg(32'hABCD_E7FF);
    send(2047, 11, 0, -1, 0, "R4 field 0x7FF");
    send(2048, 12, 0, -1, 0, "R4 one over");
    drain("R4");

    // R5 high clamp, R8 saturation
    write_reg(32'h0000_0800);
    send(2100, 13, 0, -1, 0, "R5 field 0x800");
    write_reg(32'h0000_0FFF);
    send(4200, 14, 0, -1, 0, "R5 saturated length");
    drain("R5");

    // R9 write during a frame
    write_reg(32'h0000_0600);
    send(1600, 15, 0, 100, 32'h0, "R9 mid-frame write");
    check(reg_rdata == 0, "R9", "register after mid-frame write", int'(reg_rdata), 0);
    send(1530, 16, 0, -1, 0, "R9 next frame");
    drain("R9");

    finish_run();
  end
endmodule